// File: doc/BRIEF.md
# Transmit descriptor ring walker

This block walks a ring of transmit buffer descriptors held in memory and turns the buffers they point to into a byte stream, one frame at a time. Software programs the ring start address, sets the enable bit in the control register, and then pokes the start register. The walker reads the descriptor under its current pointer. If the descriptor is marked ready, the walker reads the buffer word by word and streams its bytes. It then writes the descriptor back with the ready bit cleared and moves on. The walk ends at the first descriptor that is not ready, and the pointer is left on that descriptor so that the next poke resumes there.

A frame may span several buffers. The descriptor with its last flag set closes the frame. The final byte of the frame is marked on the output, and the frame length count restarts. Frames are limited to 2032 bytes: a buffer that would push the frame past the limit is cut short, and a babble event is pulsed. A further event pulse marks every consumed buffer, and another marks every completed frame. All memory traffic goes through one 32-bit word port with a request/acknowledge handshake.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `tx_valid_o` and all event outputs are low, and `desc_ptr_o` is 0.
- R2: A register write with `reg_sel_i`=2 starts a walk only if bit 1 of the last value written with `reg_sel_i`=0 is 1. Otherwise the write causes no memory access.
- R3: A descriptor occupies two words. The word at the pointer holds the flags in bits 31:16 and the length in bits 15:0. The word at pointer+4 holds the buffer address. Flag bit 15 is ready, bit 13 is wrap and bit 11 is last. Memory is big-endian: the byte at address a sits in word bits 31-8*(a mod 4) down to 24-8*(a mod 4).
- R4: The walk stops at the first descriptor whose ready bit is 0. At that point `busy_o` falls and `desc_ptr_o` holds that descriptor's address.
- R5: The bytes of a buffer appear on `tx_data_o` in ascending address order, for any buffer alignment. A buffer of length 0 contributes no bytes.
- R6: Bytes of consecutive buffers join into one frame, and `tx_last_o` is high only with the final byte of a frame.
- R7: A consumed descriptor's first word is written back with bit 31 cleared and every other flag bit and the length unchanged. `ev_buf_o` pulses once per consumed descriptor.
- R8: A consumed descriptor with the last flag set pulses `ev_frame_o` and restarts the frame length count at zero.
- R9: A frame longer than 2032 bytes is cut to 2032 bytes, and `ev_babble_o` pulses. A frame of exactly 2032 bytes is not cut and raises no babble.
- R10: After a descriptor with wrap set, the pointer reloads from the ring base. Otherwise it advances by 8.
- R11: A register write with `reg_sel_i`=1 sets the ring base to the written value with bits 1:0 forced to 0, and loads `desc_ptr_o` with the same value.
- R12: A start write that arrives while a walk is running is ignored and does not cause a further walk.
- R13: A memory request keeps `mem_req_o` high and `mem_addr_o` stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 ring base, 2 start |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request done; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Final byte of a frame |
| ev_buf_o | output | 1 | Pulse: buffer consumed |
| ev_frame_o | output | 1 | Pulse: frame completed |
| ev_babble_o | output | 1 | Pulse: frame truncated |
| busy_o | output | 1 | Walk in progress |
| desc_ptr_o | output | AW | Current descriptor pointer |

## Verification
A wrong descriptor pointer shows up one descriptor later. The walker then fetches the wrong address, reads wrong bytes or stops early, and `desc_ptr_o` is wrong once the walk ends. A frame length count that is not cleared, or is cleared wrongly, shows only in a later frame: that frame babbles or is cut when it should not be. A corrupt byte offset or word cache gives bad byte values within four bytes. A fault in the hold register moves `tx_last_o` away from the final byte of a frame, and this shows at the next frame close.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PTR, ST_DATA, ST_EMIT, ST_WB
  } txr_state_e;

  localparam int unsigned FLAG_READY = 15;
  localparam int unsigned FLAG_WRAP  = 13;
  localparam int unsigned FLAG_LAST  = 11;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BASE  = 2'd1;
  localparam logic [1:0] SEL_START = 2'd2;
endpackage

// File: rtl/txr_cfg.sv
module txr_cfg
  import txr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [31:0]   wdata_i,
  output logic [AW-1:0] base_o,
  output logic          base_ld_o,
  output logic [AW-1:0] base_val_o,
  output logic          start_o
);
  logic en_q;
  logic unused_wd;

  assign unused_wd  = wdata_i[0];
  assign base_val_o = {wdata_i[AW-1:2], 2'b00};
  assign base_ld_o  = we_i && (sel_i == SEL_BASE);
  assign start_o    = we_i && (sel_i == SEL_START) && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_o <= '0;
    end else begin
      if (we_i && sel_i == SEL_CTRL) en_q <= wdata_i[1];
      if (base_ld_o) base_o <= base_val_o;
    end
  end
endmodule

// File: rtl/txr_clamp.sv
module txr_clamp #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ACC_W     = 11,
  parameter int unsigned MAX_FRAME = 2032
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] eff_o,
  output logic             over_o
);
  localparam logic [LEN_W:0] MAX_V = (LEN_W+1)'(MAX_FRAME);

  logic [LEN_W:0] acc_x;
  logic [LEN_W:0] sum;
  logic [LEN_W:0] room;

  assign acc_x  = {{(LEN_W+1-ACC_W){1'b0}}, acc_i};
  assign sum    = acc_x + {1'b0, len_i};
  assign room   = MAX_V - acc_x;
  assign over_o = sum > MAX_V;
  assign eff_o  = over_o ? room[LEN_W-1:0] : len_i;
endmodule

// File: rtl/txr_frame_out.sv
module txr_frame_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  input  logic       close_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       last_o
);
  // one byte held back so the frame close can tag it
  logic       hold_vld_q;
  logic [7:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      valid_o    <= 1'b0;
      data_o     <= '0;
      last_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      if (push_i) begin
        if (hold_vld_q) begin
          valid_o <= 1'b1;
          data_o  <= hold_q;
        end
        hold_q     <= byte_i;
        hold_vld_q <= 1'b1;
      end else if (close_i && hold_vld_q) begin
        valid_o    <= 1'b1;
        data_o     <= hold_q;
        last_o     <= 1'b1;
        hold_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import txr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 2032
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          ev_buf_o,
  output logic          ev_frame_o,
  output logic          ev_babble_o,
  output logic          busy_o,
  output logic [AW-1:0] desc_ptr_o
);
  localparam int unsigned ACC_W = $clog2(MAX_FRAME + 1);

  txr_state_e       st_q;
  logic [AW-1:0]    ptr_q, buf_q;
  logic [15:0]      flags_q, len_q;
  logic [LEN_W-1:0] rem_q, eff_len;
  logic [ACC_W-1:0] acc_q;
  logic [31:0]      word_q;
  logic [7:0]       cur_byte;
  logic             over, push, close;
  logic [AW-1:0]    base, base_val;
  logic             base_ld, start;
  logic             ev_buf_q, ev_frame_q, ev_babble_q;

  txr_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_o(base), .base_ld_o(base_ld), .base_val_o(base_val), .start_o(start)
  );

  txr_clamp #(.LEN_W(LEN_W), .ACC_W(ACC_W), .MAX_FRAME(MAX_FRAME)) u_clamp (
    .acc_i(acc_q), .len_i(mem_rdata_i[LEN_W-1:0]), .eff_o(eff_len), .over_o(over)
  );

  always_comb begin
    case (buf_q[1:0])
      2'd0:    cur_byte = word_q[31:24];
      2'd1:    cur_byte = word_q[23:16];
      2'd2:    cur_byte = word_q[15:8];
      default: cur_byte = word_q[7:0];
    endcase
  end

  assign push  = (st_q == ST_EMIT);
  assign close = (st_q == ST_WB) && mem_ack_i && flags_q[FLAG_LAST];

  txr_frame_out u_out (
    .clk_i, .rst_ni,
    .push_i(push), .byte_i(cur_byte), .close_i(close),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .last_o(tx_last_o)
  );

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = {flags_q & ~(16'h1 << FLAG_READY), len_q};
    case (st_q)
      ST_HDR:  mem_addr_o = ptr_q;
      ST_PTR:  mem_addr_o = ptr_q + AW'(4);
      ST_DATA: mem_addr_o = {buf_q[AW-1:2], 2'b00};
      ST_WB:   mem_we_o   = 1'b1;
      default: mem_req_o  = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ptr_q       <= '0;
      buf_q       <= '0;
      flags_q     <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      acc_q       <= '0;
      word_q      <= '0;
      ev_buf_q    <= 1'b0;
      ev_frame_q  <= 1'b0;
      ev_babble_q <= 1'b0;
    end else begin
      ev_buf_q    <= 1'b0;
      ev_frame_q  <= 1'b0;
      ev_babble_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_HDR;
        ST_HDR: if (mem_ack_i) begin
          flags_q <= mem_rdata_i[31:16];
          if (!mem_rdata_i[16+FLAG_READY]) begin
            st_q <= ST_IDLE;
          end else begin
            len_q       <= mem_rdata_i[15:0];
            rem_q       <= eff_len;
            ev_babble_q <= over;
            st_q        <= ST_PTR;
          end
        end
        ST_PTR: if (mem_ack_i) begin
          buf_q <= mem_rdata_i[AW-1:0];
          st_q  <= (rem_q == '0) ? ST_WB : ST_DATA;
        end
        ST_DATA: if (mem_ack_i) begin
          word_q <= mem_rdata_i;
          st_q   <= ST_EMIT;
        end
        ST_EMIT: begin
          buf_q <= buf_q + AW'(1);
          rem_q <= rem_q - LEN_W'(1);
          acc_q <= acc_q + ACC_W'(1);
          if (rem_q == LEN_W'(1))     st_q <= ST_WB;
          else if (buf_q[1:0] == 2'b11) st_q <= ST_DATA;
        end
        ST_WB: if (mem_ack_i) begin
          ev_buf_q <= 1'b1;
          if (flags_q[FLAG_LAST]) begin
            ev_frame_q <= 1'b1;
            acc_q      <= '0;
          end
          ptr_q <= flags_q[FLAG_WRAP] ? base : ptr_q + AW'(8);
          st_q  <= ST_HDR;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (base_ld) ptr_q <= base_val;
    end
  end

  assign ev_buf_o    = ev_buf_q;
  assign ev_frame_o  = ev_frame_q;
  assign ev_babble_o = ev_babble_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign desc_ptr_o  = ptr_q;
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          tx_valid_o,
  input logic          tx_last_o,
  input logic          ev_buf_o,
  input logic          ev_frame_o,
  input logic          busy_o
);
  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R7
  wb_ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  // R6
  last_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  // R8
  frame_with_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_frame_o |-> ev_buf_o);

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

bind tx_ring_walker txr_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o), .ev_buf_o(ev_buf_o),
  .ev_frame_o(ev_frame_o), .busy_o(busy_o)
);

// File: tb/sim_tx_ring_walker.sv
`timescale 1ns/1ps
module sim_tx_ring_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        tx_valid_o, tx_last_o, ev_buf_o, ev_frame_o, ev_babble_o, busy_o;
  logic [7:0]  tx_data_o;
  logic [31:0] desc_ptr_o;

  int checks = 0;
  int fails = 0;
  int acc_cnt = 0;
  int n_buf = 0, n_frame = 0, n_bab = 0;
  logic [7:0] got_q[$];
  logic       lst_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] mem [4096];

  always #5 clk_i = ~clk_i;

  tx_ring_walker u0 (.*);

  initial mem_ack_i = 1'b0;
  initial mem_rdata_i = '0;

  always @(posedge clk_i) begin
    logic [11:0] a;
    a = {mem_addr_o[11:2], 2'b00};
    mem_ack_i <= mem_req_o && !mem_ack_i;
    if (mem_req_o && !mem_ack_i) begin
      acc_cnt++;
      if (mem_we_o) begin
        mem[a]   = mem_wdata_o[31:24];
        mem[a+1] = mem_wdata_o[23:16];
        mem[a+2] = mem_wdata_o[15:8];
        mem[a+3] = mem_wdata_o[7:0];
      end else begin
        mem_rdata_i <= {mem[a], mem[a+1], mem[a+2], mem[a+3]};
      end
    end
  end

  always @(negedge clk_i) begin
    if (tx_valid_o) begin
      got_q.push_back(tx_data_o);
      lst_q.push_back(tx_last_o);
    end
    if (ev_buf_o) n_buf++;
    if (ev_frame_o) n_frame++;
    if (ev_babble_o) n_bab++;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic put_desc(int a, logic [15:0] fl, logic [15:0] ln, logic [31:0] p);
    mem[a] = fl[15:8]; mem[a+1] = fl[7:0]; mem[a+2] = ln[15:8]; mem[a+3] = ln[7:0];
    mem[a+4] = p[31:24]; mem[a+5] = p[23:16]; mem[a+6] = p[15:8]; mem[a+7] = p[7:0];
  endtask

  task automatic fill(int a, int n);
    for (int k = 0; k < n; k++) begin
      mem[(a + k) % 4096] = pat(a + k);
      exp_q.push_back(pat(a + k));
    end
  endtask

  function automatic int rd16(int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic clear_mon();
    got_q.delete(); lst_q.delete(); exp_q.delete();
    n_buf = 0; n_frame = 0; n_bab = 0;
  endtask

  task automatic walk();
    int n;
    wr(2'd2, 32'h0);
    n = 0;
    while (busy_o && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    repeat (3) @(negedge clk_i);
  endtask

  task automatic cmp_frame(string req);
    int bad;
    int lbad;
    bad = 0;
    lbad = 0;
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
      if (got_q[k] != exp_q[k]) bad++;
    chk(bad == 0, {req, " byte values mismatched"}, bad, 0);
    for (int k = 0; k < lst_q.size(); k++)
      if (lst_q[k] != (k == lst_q.size() - 1)) lbad++;
    chk(lbad == 0, "R6 last flag placement errors", lbad, 0);
  endtask

  // {length, buffer address}; each is a one-descriptor frame with ready|wrap|last
  localparam logic [31:0] VEC [7] = '{
    {16'd1,    16'h0200}, {16'd5,  16'h0203}, {16'd8,  16'h0301},
    {16'd0,    16'h0400}, {16'd13, 16'h0402}, {16'd2032, 16'h0100},
    {16'd4,    16'h0500}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !mem_req_o && !tx_valid_o, "R1 idle outputs", int'(busy_o), 0);
    chk(!ev_buf_o && !ev_frame_o && !ev_babble_o, "R1 events low", int'(ev_buf_o), 0);
    chk(desc_ptr_o == 0, "R1 pointer", desc_ptr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R11 base low bits forced to zero, pointer loaded
    wr(2'd1, 32'h0000_0043);
    chk(desc_ptr_o == 32'h40, "R11 base load", desc_ptr_o, 32'h40);

    // R2 start ignored while disabled (bit 0 set is not the enable)
    put_desc(32'h40, 16'hA800, 16'd1, 32'h200);
    acc_cnt = 0;
    wr(2'd0, 32'h1);
    walk();
    repeat (5) @(negedge clk_i);
    chk(acc_cnt == 0 && !busy_o, "R2 disabled start", acc_cnt, 0);
    wr(2'd0, 32'h2);

    // table: single-descriptor frames, R3 R5 R7 R8 R9 R10
    foreach (VEC[i]) begin
      int ln, ba;
      ln = int'(VEC[i][31:16]);
      ba = int'(VEC[i][15:0]);
      clear_mon();
      put_desc(32'h40, 16'hA800, 16'(ln), 32'(ba));
      fill(ba, ln);
      walk();
      cmp_frame("R5");
      chk(n_buf == 1 && n_frame == 1, "R8 frame event count", n_frame, 1);
      chk(n_bab == 0, "R9 no babble within limit", n_bab, 0);
      chk(rd16(32'h40) == 16'h2800 && rd16(32'h42) == ln, "R7 writeback", rd16(32'h40), 16'h2800);
      chk(desc_ptr_o == 32'h40, "R10 wrap to base", desc_ptr_o, 32'h40);
    end

    // multi-buffer frame without wrap, R4 R6 R10
    clear_mon();
    put_desc(32'h40, 16'h8000, 16'd3, 32'h600);
    put_desc(32'h48, 16'h8000, 16'd6, 32'h605);
    put_desc(32'h50, 16'h8800, 16'd2, 32'h613);
    put_desc(32'h58, 16'h0800, 16'd1, 32'h700);
    fill(32'h600, 3); fill(32'h605, 6); fill(32'h613, 2);
    walk();
    cmp_frame("R6");
    chk(n_buf == 3 && n_frame == 1, "R7 buffer events", n_buf, 3);
    chk(desc_ptr_o == 32'h58, "R4 stop pointer", desc_ptr_o, 32'h58);
    chk(!busy_o, "R4 busy falls", int'(busy_o), 0);
    chk(rd16(32'h48) == 16'h0000 && rd16(32'h4A) == 6, "R7 middle writeback", rd16(32'h48), 0);

    // R4 resume from the stopped descriptor
    clear_mon();
    put_desc(32'h58, 16'hA800, 16'd1, 32'h700);
    fill(32'h700, 1);
    walk();
    cmp_frame("R4 resume");
    chk(desc_ptr_o == 32'h40, "R10 wrap after resume", desc_ptr_o, 32'h40);

    // R9 truncation, R12 start while busy
    clear_mon();
    put_desc(32'h40, 16'h8000, 16'd2000, 32'h100);
    put_desc(32'h48, 16'hA800, 16'd100, 32'h900);
    fill(32'h100, 2000);
    for (int k = 0; k < 100; k++) mem[32'h900 + k] = pat(32'h900 + k);
    for (int k = 0; k < 32; k++) exp_q.push_back(pat(32'h900 + k));
    wr(2'd2, 32'h0);
    repeat (20) @(negedge clk_i);
    wr(2'd2, 32'h0);
    while (busy_o) @(negedge clk_i);
    acc_cnt = 0;
    repeat (10) @(negedge clk_i);
    chk(acc_cnt == 0 && !busy_o, "R12 no second walk", acc_cnt, 0);
    cmp_frame("R9");
    chk(n_bab == 1, "R9 babble event", n_bab, 1);
    chk(n_frame == 1, "R12 single frame", n_frame, 1);
    chk(rd16(32'h4A) == 100, "R7 length kept", rd16(32'h4A), 100);

    // R8 count restarted: a following small frame is not cut
    clear_mon();
    put_desc(32'h40, 16'hA800, 16'd7, 32'hA00);
    fill(32'hA00, 7);
    walk();
    cmp_frame("R8");
    chk(n_bab == 0, "R8 no babble after reset of count", n_bab, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule